// File: doc/BRIEF.md
# Pipelined DES Round Engine

This block computes one round of the DES Feistel network per clock cycle. Each cycle it can take a fresh pair of 32-bit halves together with a 48-bit round key. Four clock edges later it delivers the next pair of halves. The old right half becomes the new left half. The new right half is the old left half XORed with the round function of the old right half and the key.

The round function runs in a fixed sequence of register stages:
- The right half is expanded to 48 bits and mixed with the key.
- Each of the eight 6-bit groups first selects a row of its substitution box, and then a 4-bit column entry from that row.
- The 32-bit substitution result is permuted and folded into the left half.

A valid flag and both halves travel alongside the datapath, so every result leaves aligned with its own input. The block does no key scheduling and no initial or final permutation. A full cipher chains sixteen copies behind an external key schedule.

Top module: `des_round_pipe`

## Requirements
- R1: After a synchronous active-low reset, `out_valid`, `out_left` and `out_right` are all zero until the first accepted input has travelled through the pipeline.
- R2: An input accepted with `in_valid` high at a rising edge produces `out_valid` high right after the fourth rising edge, counting the accepting edge as the first.
- R3: `out_left` equals the `in_right` of the same item, whatever the key and left half are.
- R4: `out_right` equals the item's `in_left` XOR f(`in_right`, `in_key`). Changing only `in_left` changes `out_right` by exactly the XOR difference of the two left halves.
- R5: Items may enter on every consecutive cycle. They leave on consecutive cycles in the same order, with no item lost or repeated.
- R6: f is the standard DES round function. The expansion takes output bit i (1 = MSB) from input bit 4*floor((i-1)/6) + ((i-1) mod 6), with 0 read as 32 and 33 read as 1. The eight S-boxes take 6-bit groups, with S1 taking the most significant group. Each box uses the outer bits (b1,b6) as the row and the inner four bits as the column. The standard P permutation follows. For example, right half F0AAF0AA with key 1B02EFFC7072 gives f = 234AA9BB.
- R7: A cycle in which `in_valid` is low produces a cycle with `out_valid` low four edges later, so bubbles are never turned into results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input item present this cycle |
| in_left | input | 32 | Left half entering the round |
| in_right | input | 32 | Right half entering the round |
| in_key | input | 48 | Round key for this item |
| out_valid | output | 1 | Result present this cycle |
| out_left | output | 32 | New left half (the old right half) |
| out_right | output | 32 | New right half (old left XOR f) |

## Verification
A corrupted substitution entry or permutation wire shows up only in `out_right`, and only for items whose group values reach the damaged entry. For that reason the known-answer items drawn from a real cipher run cover every box with several distinct rows. A misaligned carry register for a half or the valid flag shows up four edges after entry: an item appears one cycle early or late, or its `out_left` belongs to a neighbour. Back-to-back streams with interleaved bubbles expose these faults immediately.

// File: rtl/des_round_pkg.sv
// Package: shared widths and constant tables for the DES round pipeline.
// Assumes DES bit numbering where bit 1 is the most significant bit.
package des_round_pkg;
    localparam int HALF_W  = 32;
    localparam int NUM_BOX = 8;
    localparam int GRP_W   = 6;
    localparam int NIB_W   = 4;
    localparam int COLS    = 16;
    localparam int ROW_W   = COLS * NIB_W;
    localparam int KEY_W   = NUM_BOX * GRP_W;

    // Source index (0-based from MSB) of expansion output position pos.
    function automatic int exp_src(input int pos);
        int grp;
        int k;
        grp = pos / GRP_W;
        k   = pos % GRP_W;
        return (NIB_W * grp + k + HALF_W - 1) % HALF_W;
    endfunction

    // Source bit (1-based) feeding output bit i (1-based) of the P permutation.
    function automatic int perm_src(input int i);
        case (i)
            1: return 16;  2: return 7;   3: return 20;  4: return 21;
            5: return 29;  6: return 12;  7: return 28;  8: return 17;
            9: return 1;   10: return 15; 11: return 23; 12: return 26;
            13: return 5;  14: return 18; 15: return 31; 16: return 10;
            17: return 2;  18: return 8;  19: return 24; 20: return 14;
            21: return 32; 22: return 27; 23: return 3;  24: return 9;
            25: return 19; 26: return 13; 27: return 30; 28: return 6;
            29: return 22; 30: return 11; 31: return 4;  default: return 25;
        endcase
    endfunction

    // One row of a substitution box, column 0 in the top nibble.
    function automatic logic [ROW_W-1:0] sbox_row(input int box, input logic [1:0] row);
        case ({box[2:0], row})
            5'b000_00: return 64'hE4D12FB83A6C5907;
            5'b000_01: return 64'h0F74E2D1A6CB9538;
            5'b000_10: return 64'h41E8D62BFC973A50;
            5'b000_11: return 64'hFC8249175B3EA06D;
            5'b001_00: return 64'hF18E6B34972DC05A;
            5'b001_01: return 64'h3D47F28EC01A69B5;
            5'b001_10: return 64'h0E7BA4D158C6932F;
            5'b001_11: return 64'hD8A13F42B67C05E9;
            5'b010_00: return 64'hA09E63F51DC7B428;
            5'b010_01: return 64'hD709346A285ECBF1;
            5'b010_10: return 64'hD6498F30B12C5AE7;
            5'b010_11: return 64'h1AD069874FE3B52C;
            5'b011_00: return 64'h7DE3069A1285BC4F;
            5'b011_01: return 64'hD8B56F03472C1AE9;
            5'b011_10: return 64'hA690CB7DF13E5284;
            5'b011_11: return 64'h3F06A1D8945BC72E;
            5'b100_00: return 64'h2C417AB6853FD0E9;
            5'b100_01: return 64'hEB2C47D150FA3986;
            5'b100_10: return 64'h421BAD78F9C5630E;
            5'b100_11: return 64'hB8C71E2D6F09A453;
            5'b101_00: return 64'hC1AF92680D34E75B;
            5'b101_01: return 64'hAF427C9561DE0B38;
            5'b101_10: return 64'h9EF528C3704A1DB6;
            5'b101_11: return 64'h432C95FABE17608D;
            5'b110_00: return 64'h4B2EF08D3C975A61;
            5'b110_01: return 64'hD0B7491AE35C2F86;
            5'b110_10: return 64'h14BDC37EAF680592;
            5'b110_11: return 64'h6BD814A7950FE23C;
            5'b111_00: return 64'hD2846FB1A93E50C7;
            5'b111_01: return 64'h1FD8A374C56B0E92;
            5'b111_10: return 64'h7B419CE206ADF358;
            default:   return 64'h21E74A8DFC90356B;
        endcase
    endfunction
endpackage

// File: rtl/des_round_mix.sv
// Stage 1: expands the right half to key width and XORs in the round key.
// Carries valid and both halves. Assumes synchronous active-low reset.
module des_round_mix
    import des_round_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [HALF_W-1:0] in_left,
    input  logic [HALF_W-1:0] in_right,
    input  logic [KEY_W-1:0]  in_key,
    output logic              mix_valid,
    output logic [HALF_W-1:0] mix_left,
    output logic [HALF_W-1:0] mix_right,
    output logic [KEY_W-1:0]  mix_bits
);
    logic [KEY_W-1:0] expanded;

    // Wire the expansion from the computed source map.
    for (genvar p = 0; p < KEY_W; p++) begin : g_exp
        assign expanded[KEY_W-1-p] = in_right[HALF_W-1-exp_src(p)];
    end

    // Register the keyed expansion and the carried halves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mix_valid <= 1'b0;
            mix_left  <= '0;
            mix_right <= '0;
            mix_bits  <= '0;
        end else begin
            mix_valid <= in_valid;
            mix_left  <= in_left;
            mix_right <= in_right;
            mix_bits  <= expanded ^ in_key;
        end
    end
endmodule

// File: rtl/des_round_subst.sv
// Stages 2 and 3: two-cycle substitution. First each group picks a box row
// from its outer bits, then the inner bits pick the nibble from that row.
module des_round_subst
    import des_round_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mix_valid,
    input  logic [HALF_W-1:0] mix_left,
    input  logic [HALF_W-1:0] mix_right,
    input  logic [KEY_W-1:0]  mix_bits,
    output logic              sub_valid,
    output logic [HALF_W-1:0] sub_left,
    output logic [HALF_W-1:0] sub_right,
    output logic [HALF_W-1:0] sub_bits
);
    logic [NUM_BOX-1:0][ROW_W-1:0] row_q;
    logic [NUM_BOX-1:0][NIB_W-1:0] col_q;
    logic [NUM_BOX-1:0][ROW_W-1:0] row_d;
    logic [HALF_W-1:0]             nib_d;
    logic              mid_valid;
    logic [HALF_W-1:0] mid_left;
    logic [HALF_W-1:0] mid_right;

    for (genvar b = 0; b < NUM_BOX; b++) begin : g_box
        logic [GRP_W-1:0] grp;
        logic [ROW_W-1:0] shifted;
        assign grp      = mix_bits[KEY_W-1-b*GRP_W -: GRP_W];
        assign row_d[b] = sbox_row(b, {grp[GRP_W-1], grp[0]});
        assign shifted  = row_q[b] >> (ROW_W - NIB_W - NIB_W * int'(col_q[b]));
        assign nib_d[HALF_W-1-b*NIB_W -: NIB_W] = shifted[NIB_W-1:0];

        // Row selection register with the column index held beside it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row_q[b] <= '0;
                col_q[b] <= '0;
            end else begin
                row_q[b] <= row_d[b];
                col_q[b] <= grp[GRP_W-2:1];
            end
        end
    end

    // Carry valid and halves through the middle stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mid_valid <= 1'b0;
            mid_left  <= '0;
            mid_right <= '0;
        end else begin
            mid_valid <= mix_valid;
            mid_left  <= mix_left;
            mid_right <= mix_right;
        end
    end

    // Register the column-selected nibbles with the carried halves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sub_valid <= 1'b0;
            sub_left  <= '0;
            sub_right <= '0;
            sub_bits  <= '0;
        end else begin
            sub_valid <= mid_valid;
            sub_left  <= mid_left;
            sub_right <= mid_right;
            sub_bits  <= nib_d;
        end
    end
endmodule

// File: rtl/des_round_merge.sv
// Stage 4: permutes the substitution output and folds it into the left half.
// The old right half becomes the new left half.
module des_round_merge
    import des_round_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sub_valid,
    input  logic [HALF_W-1:0] sub_left,
    input  logic [HALF_W-1:0] sub_right,
    input  logic [HALF_W-1:0] sub_bits,
    output logic              out_valid,
    output logic [HALF_W-1:0] out_left,
    output logic [HALF_W-1:0] out_right
);
    logic [HALF_W-1:0] permuted;

    // Wire the P permutation from its table.
    for (genvar i = 1; i <= HALF_W; i++) begin : g_perm
        assign permuted[HALF_W-i] = sub_bits[HALF_W-perm_src(i)];
    end

    // Register the new halves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_left  <= '0;
            out_right <= '0;
        end else begin
            out_valid <= sub_valid;
            out_left  <= sub_right;
            out_right <= sub_left ^ permuted;
        end
    end
endmodule

// File: rtl/des_round_pipe.sv
// Top: one DES round per cycle, four-cycle fixed latency, valid carried along.
// Assumes the key schedule is supplied externally, one key per item.
module des_round_pipe
    import des_round_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       in_left,
    input  logic [31:0]       in_right,
    input  logic [47:0]       in_key,
    output logic              out_valid,
    output logic [31:0]       out_left,
    output logic [31:0]       out_right
);
    localparam int LAT = 4;

    logic              mix_valid, sub_valid;
    logic [HALF_W-1:0] mix_left, mix_right, sub_left, sub_right, sub_bits;
    logic [KEY_W-1:0]  mix_bits;

    des_round_mix u_mix (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
        .in_right(in_right), .in_key(in_key), .mix_valid(mix_valid),
        .mix_left(mix_left), .mix_right(mix_right), .mix_bits(mix_bits)
    );

    des_round_subst u_subst (
        .clk(clk), .rst_n(rst_n), .mix_valid(mix_valid), .mix_left(mix_left),
        .mix_right(mix_right), .mix_bits(mix_bits), .sub_valid(sub_valid),
        .sub_left(sub_left), .sub_right(sub_right), .sub_bits(sub_bits)
    );

    des_round_merge u_merge (
        .clk(clk), .rst_n(rst_n), .sub_valid(sub_valid), .sub_left(sub_left),
        .sub_right(sub_right), .sub_bits(sub_bits), .out_valid(out_valid),
        .out_left(out_left), .out_right(out_right)
    );

    // Edges since reset release, saturating; guards the history-based checks.
    logic [3:0] since_rst;
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_rst <= '0;
        else if (since_rst != 4'hF) since_rst <= since_rst + 4'd1;
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 4'd0) |-> (!out_valid && out_left == '0 && out_right == '0));

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 4'(LAT)) |-> (out_valid == $past(in_valid, 4)));

    assert_left_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 4'(LAT) && out_valid) |-> (out_left == $past(in_right, 4)));

    assert_back_to_back_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 4'd1 && in_valid && $past(in_valid)) |-> ##4 (out_valid && $past(out_valid)));

    assert_bubble_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid) |-> ##4 (!out_valid));
endmodule

// File: tb/des_round_pipe_test.sv
// Scoreboard bench: the driver queues expected results, the monitor compares.
module des_round_pipe_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] in_left, in_right;
    logic [47:0] in_key;
    logic        out_valid;
    logic [31:0] out_left, out_right;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int pushed = 0;
    int popped = 0;

    logic [31:0] exp_l_q[$];
    logic [31:0] exp_r_q[$];
    int          exp_t_q[$];

    // Known (right, key, f) triples from a real cipher run, rounds 1..4.
    logic [31:0] kr [4] = '{32'hF0AAF0AA, 32'hEF4A6544, 32'hCC017709, 32'hA25C0BF4};
    logic [47:0] kk [4] = '{48'h1B02EFFC7072, 48'h79AED9DBC9E5, 48'h55FC8A42CF99, 48'h72ADD6DB351D};
    logic [31:0] kf [4] = '{32'h234AA9BB, 32'h3CAB87A3, 32'h4D166EB0, 32'hBB23774C};
    logic [31:0] kl [4] = '{32'hCC00CCFF, 32'hF0AAF0AA, 32'hEF4A6544, 32'hCC017709};

    des_round_pipe uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
        .in_right(in_right), .in_key(in_key), .out_valid(out_valid),
        .out_left(out_left), .out_right(out_right)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one item (or a bubble) for one cycle; inputs change at negedge.
    task automatic drive(input bit v, input logic [31:0] l, input logic [31:0] r,
                         input logic [47:0] k, input logic [31:0] f);
        in_valid = v;
        in_left  = l;
        in_right = r;
        in_key   = k;
        if (v) begin
            exp_l_q.push_back(r);
            exp_r_q.push_back(l ^ f);
            exp_t_q.push_back(cyc + 1);
            pushed++;
        end
        @(negedge clk);
    endtask

    // Monitor: compare each result against the queue head (R2..R7).
    always @(negedge clk) begin
        if (rst_n === 1'b1 && out_valid === 1'b1) begin
            if (exp_l_q.size() == 0) begin
                check(1'b0, "R7 unexpected result", {63'd0, out_valid}, 64'd0);
            end else begin
                logic [31:0] el, er;
                int et;
                el = exp_l_q.pop_front();
                er = exp_r_q.pop_front();
                et = exp_t_q.pop_front();
                popped++;
                check(cyc - et == 3, "R2 latency", 64'(cyc - et), 64'd3);
                check(out_left == el, "R3 left pass", {32'd0, out_left}, {32'd0, el});
                check(out_right == er, "R4/R6 right", {32'd0, out_right}, {32'd0, er});
            end
        end
    end

    initial begin
        rst_n = 1'b0;
        in_valid = 1'b0; in_left = '0; in_right = '0; in_key = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state visible at the ports
        check(out_valid == 1'b0 && out_left == '0 && out_right == '0, "R1 reset",
              {out_left, out_right}, 64'd0);

        // R6: known-answer rounds, back to back (R5)
        for (int i = 0; i < 4; i++) drive(1'b1, kl[i], kr[i], kk[i], kf[i]);
        drive(1'b0, '0, '0, '0, '0);
        drive(1'b0, '0, '0, '0, '0);

        // R4: vary only the left half; right output moves by the XOR difference
        for (int i = 0; i < 16; i++) begin
            logic [31:0] lv;
            lv = 32'h9E3779B9 * (i + 1) ^ (32'h1 << i);
            drive(1'b1, lv, kr[i % 4], kk[i % 4], kf[i % 4]);
        end

        // R7: bubbles interleaved with items
        for (int i = 0; i < 12; i++) begin
            if (i % 3 == 0) drive(1'b1, 32'h0F0F0000 + i, kr[i % 4], kk[i % 4], kf[i % 4]);
            else            drive(1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 48'hFFFFFFFFFFFF, '0);
        end

        // R5: long uninterrupted stream of mixed items
        for (int i = 0; i < 20; i++) drive(1'b1, ~(32'h12345678 + i), kr[(i+1) % 4], kk[(i+1) % 4], kf[(i+1) % 4]);
        in_valid = 1'b0;
        repeat (8) @(negedge clk);

        // R5/R7: every item came out exactly once
        check(popped == pushed && exp_l_q.size() == 0, "R5 count", 64'(popped), 64'(pushed));
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule